// File: doc/BRIEF.md
# Pseudo-Random Stimulus and XOR-Checksum Sequencer

This block drives a 4x4 matrix transform engine and reduces everything the engine returns to one 8-bit signature. A 14-bit LFSR supplies every word it drives. After a `go` pulse, it first loads sixteen 9-bit coefficients into the engine. It then streams 64 four-word coordinate vectors in continuous mode. Every valid word from the engine is folded into an 8-bit XOR accumulator.

The sequencer never assumes a latency. A new vector is offered only when the engine raises `eng_input_rdy`, and results are taken only when `eng_output_rdy` is high. Because of this, any correct engine gives the same signature for a given seed, however fast or slow it is. A 5-bit seed changes the starting LFSR state, so one design can be tested against several independent streams.

Top module: `xsum_seq`

## Requirements
- R1: After reset `eng_cf_load`, `eng_start`, `done` and `checksum` are all 0, and they stay 0 until `go` is seen.
- R2: The LFSR is a left-shifting Fibonacci register with feedback bit s[13]^s[4]^s[2]^s[0] (polynomial x^14+x^5+x^3+x+1). On `go` it is set to {9'h1FF, seed}. It advances exactly once for each word placed on `eng_din`, and it is never all zeros.
- R3: After `go`, `eng_cf_load` is high for exactly 16 consecutive cycles. In each of them `eng_din` carries the low 9 bits of the current LFSR state, so the coefficients are the first 16 words of the stream.
- R4: A vector's first coordinate is offered in a cycle where `eng_input_rdy` and `eng_start` are both high. The next three coordinates follow on the three cycles after it. Each coordinate is {1'b0, low 8 LFSR bits}, and `eng_cf_load` and `eng_start` are never high together.
- R5: Exactly 64 vectors are offered. `eng_start` stays high up to and including the cycle that offers the first coordinate of vector 64, and it is low from the very next cycle onward.
- R6: `checksum` is cleared when a run starts. During a run, it XORs in `eng_dout` on every cycle where `eng_output_rdy` is high, and it is unchanged on every other cycle.
- R7: `done` rises in the cycle after the 256th valid output word is accumulated. While `done` is high, `checksum` and `done` hold until the next `go`.
- R8: A `go` pulse during a run has no effect: the run's coefficients, coordinates and final checksum are those of the original start.
- R9: The final checksum depends only on the seed and the engine's arithmetic, not on how many cycles the engine takes between vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Starts a run from idle or done |
| seed | input | 5 | Low bits of the initial LFSR state |
| eng_input_rdy | input | 1 | Engine can accept a new vector |
| eng_output_rdy | input | 1 | `eng_dout` holds a valid result word |
| eng_dout | input | 8 | Result word from the engine |
| eng_din | output | 9 | Coefficient or coordinate word to the engine |
| eng_cf_load | output | 1 | Coefficient load strobe |
| eng_start | output | 1 | Vector start, held high for continuous mode |
| checksum | output | 8 | XOR of all accumulated result words |
| done | output | 1 | Run finished, all 256 words accumulated |

## Verification
Some rules are checked on every cycle by the assertions. They cover the mutual exclusion of the load and start strobes, and that the checksum changes only when a result word is valid or a run starts. They also confirm that done holds with a frozen signature, that the strobes stay quiet after completion, and that the LFSR never reaches zero. Other properties need complete runs. These are the exact 9-bit and 8-bit word stream for a given seed, that start drops in the cycle right after vector 64 is offered, that the final signature matches, and that a repeated go changes nothing. The bench shows them by sweeping all 32 seeds against an engine model at several initiation intervals.

// File: rtl/xsum_seq.sv
module xsum_seq #(
  parameter int NCOEF  = 16,
  parameter int NVEC   = 64,
  parameter int VWORDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [4:0] seed,
  input  logic       eng_input_rdy,
  input  logic       eng_output_rdy,
  input  logic [7:0] eng_dout,
  output logic [8:0] eng_din,
  output logic       eng_cf_load,
  output logic       eng_start,
  output logic [7:0] checksum,
  output logic       done
);
  localparam int NOUT = NVEC * VWORDS;
  localparam int WW   = $clog2(NCOEF);
  localparam int VW   = $clog2(NVEC + 1);
  localparam int OW   = $clog2(NOUT + 1);
  localparam logic [WW-1:0] W_LOAD_LAST = WW'(NCOEF - 1);
  localparam logic [WW-1:0] W_VEC_LAST  = WW'(VWORDS - 2);
  localparam logic [VW-1:0] V_LAST      = VW'(NVEC);
  localparam logic [OW-1:0] O_LAST      = OW'(NOUT - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_VEC, S_DRAIN, S_DONE} st_t;

  st_t           st;
  logic [13:0]   lfsr;
  logic [WW-1:0] wcnt;
  logic [VW-1:0] vcnt;
  logic [OW-1:0] ocnt;

  wire fb     = lfsr[13] ^ lfsr[4] ^ lfsr[2] ^ lfsr[0];
  wire active = (st == S_LOAD) || (st == S_WAIT) || (st == S_VEC) || (st == S_DRAIN);
  wire adv    = (st == S_LOAD) || (st == S_VEC) || ((st == S_WAIT) && eng_input_rdy);

  assign eng_cf_load = (st == S_LOAD);
  assign eng_start   = (st == S_WAIT) || ((st == S_VEC) && (vcnt != V_LAST));
  assign eng_din     = (st == S_LOAD) ? lfsr[8:0] :
                       ((st == S_WAIT) || (st == S_VEC)) ? {1'b0, lfsr[7:0]} : 9'd0;
  assign done        = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lfsr     <= '1;
      wcnt     <= '0;
      vcnt     <= '0;
      ocnt     <= '0;
      checksum <= '0;
    end else begin
      if (adv) lfsr <= {lfsr[12:0], fb};
      if (active && eng_output_rdy) begin
        checksum <= checksum ^ eng_dout;
        ocnt     <= ocnt + 1'b1;
      end
      case (st)
        S_IDLE, S_DONE: if (go) begin
          lfsr     <= {9'h1FF, seed};
          checksum <= '0;
          ocnt     <= '0;
          vcnt     <= '0;
          wcnt     <= '0;
          st       <= S_LOAD;
        end
        S_LOAD: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == W_LOAD_LAST) begin
            wcnt <= '0;
            st   <= S_WAIT;
          end
        end
        S_WAIT: if (eng_input_rdy) begin
          vcnt <= vcnt + 1'b1;
          wcnt <= '0;
          st   <= S_VEC;
        end
        S_VEC: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == W_VEC_LAST) st <= (vcnt == V_LAST) ? S_DRAIN : S_WAIT;
        end
        default: ;
      endcase
      if (active && eng_output_rdy && ocnt == O_LAST) st <= S_DONE;
    end
  end
endmodule

// File: rtl/xsum_seq_chk.sv
module xsum_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        cf_load,
  input logic        start,
  input logic        output_rdy,
  input logic [7:0]  checksum,
  input logic        done,
  input logic [13:0] lfsr
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cf_load && start)); // R4
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 14'd0); // R2
  AST_SUM_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!output_rdy && !go) |=> $stable(checksum)); // R6
  AST_SUM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (done && go) |=> (checksum == 8'd0) && !done); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !go) |=> done && $stable(checksum)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!cf_load && !start)); // R5
endmodule

bind xsum_seq xsum_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .cf_load(eng_cf_load), .start(eng_start),
  .output_rdy(eng_output_rdy), .checksum(checksum), .done(done), .lfsr(lfsr)
);

// File: tb/xsum_seq_test.sv
module xsum_seq_test;
  logic clk = 0, rst_n = 0, go = 0;
  logic [4:0] seed = 0;
  logic e_rdy, o_rdy;
  logic [7:0] o_dat;
  logic [8:0] din;
  logic cf_load, start, done;
  logic [7:0] checksum;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xsum_seq uut (
    .clk(clk), .rst_n(rst_n), .go(go), .seed(seed),
    .eng_input_rdy(e_rdy), .eng_output_rdy(o_rdy), .eng_dout(o_dat),
    .eng_din(din), .eng_cf_load(cf_load), .eng_start(start),
    .checksum(checksum), .done(done)
  );

  // engine model with a selectable initiation interval
  int gap = 5;
  bit eng_clr = 0;
  logic [8:0] ecoef [16];
  logic [7:0] ecrd [256];
  logic [7:0] ev [4];
  logic [7:0] oq [4];
  int ncoef, ncrd, nx, eph, wcnt, ocnt;
  bit last_x, start_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_rdy <= 1; o_rdy <= 0; o_dat <= 0;
      ncoef <= 0; ncrd <= 0; nx <= 0; eph <= 0; wcnt <= 0; ocnt <= 0;
      last_x <= 0; start_ok <= 0;
    end else begin
      if (eng_clr) begin
        ncoef <= 0; ncrd <= 0; nx <= 0; start_ok <= 0;
      end
      if (cf_load) begin
        if (ncoef < 16) ecoef[ncoef] <= din;
        ncoef <= ncoef + 1;
      end
      last_x <= 0;
      if (last_x) start_ok <= !start;
      case (eph)
        0: if (e_rdy && start) begin
          ev[0] <= din[7:0];
          if (ncrd < 256) ecrd[ncrd] <= din[7:0];
          ncrd <= ncrd + 1; nx <= nx + 1;
          last_x <= (nx == 63);
          e_rdy <= 0; eph <= 1;
        end
        1, 2: begin
          ev[eph] <= din[7:0];
          if (ncrd < 256) ecrd[ncrd] <= din[7:0];
          ncrd <= ncrd + 1; eph <= eph + 1;
        end
        3: begin
          if (ncrd < 256) ecrd[ncrd] <= din[7:0];
          ncrd <= ncrd + 1;
          for (int i = 0; i < 4; i++) begin
            int acc;
            acc = ecoef[4*i]*ev[0] + ecoef[4*i+1]*ev[1] + ecoef[4*i+2]*ev[2] + ecoef[4*i+3]*din[7:0];
            oq[i] <= acc[7:0];
          end
          ocnt <= 4; wcnt <= gap - 5; eph <= 4;
        end
        default: if (wcnt == 0) begin e_rdy <= 1; eph <= 0; end else wcnt <= wcnt - 1;
      endcase
      if (ocnt > 0) begin
        o_rdy <= 1; o_dat <= oq[4-ocnt]; ocnt <= ocnt - 1;
      end else o_rdy <= 0;
    end
  end

  function automatic logic [13:0] step(input logic [13:0] s);
    return {s[12:0], s[13] ^ s[4] ^ s[2] ^ s[0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_run(input logic [4:0] sd, input int g, input bit midgo);
    logic [13:0] s;
    logic [8:0] xc [16];
    logic [7:0] xv [256];
    logic [7:0] xs;
    int t, bad, badi;
    logic [7:0] held;
    s = {9'h1FF, sd};
    for (int k = 0; k < 16; k++) begin xc[k] = s[8:0]; s = step(s); end
    for (int k = 0; k < 256; k++) begin xv[k] = s[7:0]; s = step(s); end
    xs = 0;
    for (int n = 0; n < 64; n++)
      for (int i = 0; i < 4; i++) begin
        int acc;
        acc = 0;
        for (int j = 0; j < 4; j++) acc += xc[4*i+j] * xv[4*n+j];
        xs ^= acc[7:0];
      end
    @(negedge clk); gap = g; seed = sd; eng_clr = 1;
    @(negedge clk); eng_clr = 0; go = 1;
    @(negedge clk); go = 0;
    if (midgo) begin
      repeat (100) @(negedge clk);
      go = 1; @(negedge clk); go = 0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(done, "R7 done after 256 words", done, 1);
    check(ncoef == 16, "R3 cf_load cycle count", ncoef, 16);
    bad = 0; badi = 0;
    for (int k = 0; k < 16; k++) if (ecoef[k] !== xc[k] && bad == 0) begin bad = 1; badi = k; end
    check(bad == 0, "R2 R3 coefficient stream", ecoef[badi], xc[badi]);
    bad = 0; badi = 0;
    for (int k = 0; k < 256; k++) if (ecrd[k] !== xv[k] && bad == 0) begin bad = 1; badi = k; end
    check(bad == 0 && ncrd == 256, "R2 R4 coordinate stream", ecrd[badi], xv[badi]);
    check(nx == 64 && start_ok, "R5 vector count and start drop", nx, 64);
    check(checksum == xs, midgo ? "R8 R9 checksum" : "R6 R9 checksum", checksum, xs);
    held = checksum;
    repeat (20) @(negedge clk);
    check(done && checksum == held && !start && !cf_load, "R7 hold after done", checksum, held);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cf_load && !start && !done && checksum == 0, "R1 reset state", checksum, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(!cf_load && !start && !done && checksum == 0, "R1 idle before go", {cf_load, start, done}, 0);
    for (int sd = 0; sd < 32; sd++) do_run(sd[4:0], 5, 0);
    for (int sd = 0; sd < 32; sd += 3) do_run(sd[4:0], 12, 0);
    for (int sd = 1; sd < 32; sd += 7) do_run(sd[4:0], 8, 0);
    do_run(5'd7, 8, 1);
    do_run(5'd22, 12, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule